// File: doc/BRIEF.md
# Two-Port Keyboard/Mouse Controller Register Front-End

This block sits between a host register bus and two byte-stream devices: a primary (keyboard) port and a secondary (mouse) port. The host sees a data register and a shared status/command register. Bytes from either device are captured into a single output register. The host reads them from there, and a status bit tells the host which port delivered the byte. Bytes the host writes to the data register go out on the primary port's transmit channel. A short two-step command protocol lets the host redirect the next written byte to the secondary port, rewrite the internal configuration byte, or fetch that byte back through the data register.

The configuration byte gates each port's receive path and each port's interrupt. It also carries a system flag and a translation request. Both of those are kept but have no effect on the data here. After every host write, an input-busy status flag stays raised for a fixed number of cycles, to mimic a controller's processing delay. Line-level clocking and code translation are outside the block: each device side is a plain valid/ready byte channel.

Top module: `ps2_regfront`

## Requirements
- R1: The data register sits at offset 0 and the status/command register at offset 4. A write to any other offset changes nothing, and a read from any other offset returns 0x00.
- R2: The status byte has bit 0 = output register full, bit 1 = input busy, and bit 5 = output byte came from the secondary port. All other status bits read 0. Reading status changes no state.
- R3: Command 0x60 makes the next data-register write become the configuration byte, with bits 3 and 7 forced to 0. Command 0x20 loads the configuration byte into the output register with the source bit cleared. The configuration byte resets to 0x04.
- R4: A data-register write with no command pending goes to the primary transmit channel. After command 0xD4, the next data write goes to the secondary transmit channel instead. One data write consumes a pending command, and any other command code cancels it.
- R5: A transmit channel keeps valid high with stable data until its ready is seen.
- R6: The output register accepts a device byte only while it is empty. The primary port wins when both offer at once, and a byte from the secondary port sets status bit 5.
- R7: Configuration bit 4 holds the primary receive ready low, and bit 5 holds the secondary receive ready low. A disabled port's byte never reaches the output register.
- R8: Reading the data register returns the output byte and clears the full flag at that clock edge.
- R9: The primary interrupt is high only while the output register is full with a primary-port byte and configuration bit 0 is set. The secondary interrupt works the same way with a secondary-port byte and bit 1.
- R10: Each write to offset 0 or 4 holds status bit 1 high for exactly BUSY_CYCLES cycles after the write edge.
- R11: Configuration bit 6 (translation request) is stored and read back, and received bytes pass through it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data, valid in the cycle bus_rd is high |
| kb_rx_valid | input | 1 | Primary device offers a byte |
| kb_rx_data | input | 8 | Primary device byte |
| kb_rx_ready | output | 1 | Output register takes the primary byte |
| aux_rx_valid | input | 1 | Secondary device offers a byte |
| aux_rx_data | input | 8 | Secondary device byte |
| aux_rx_ready | output | 1 | Output register takes the secondary byte |
| kb_tx_valid | output | 1 | Byte pending for the primary device |
| kb_tx_data | output | 8 | Byte for the primary device |
| kb_tx_ready | input | 1 | Primary device takes the byte |
| aux_tx_valid | output | 1 | Byte pending for the secondary device |
| aux_tx_data | output | 8 | Byte for the secondary device |
| aux_tx_ready | input | 1 | Secondary device takes the byte |
| irq_kb | output | 1 | Primary port interrupt |
| irq_aux | output | 1 | Secondary port interrupt |

## Verification
Read data is combinational, so the bench samples bus_rdata in the same cycle it raises bus_rd. Every register effect of a write, a read or a device handshake shows up after the next rising edge, so the bench checks it at the falling edge that follows. The busy flag is due for exactly BUSY_CYCLES falling edges after the write edge. The bench reads status once per cycle across that window and expects the flag to clear on the last read. Receive-path checks wait out the busy window before comparing the full status byte, so bit 1 cannot mask a tagging error.

// File: rtl/ps2rf_pkg.sv
package ps2rf_pkg;
    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_CFG  = 2'd1,
        PEND_AUX  = 2'd2
    } pend_e;

    localparam logic [7:0] OP_WR_CFG = 8'h60;
    localparam logic [7:0] OP_RD_CFG = 8'h20;
    localparam logic [7:0] OP_TO_AUX = 8'hD4;
    localparam logic [7:0] CFG_MASK  = 8'h77;

    localparam int CFG_IRQ_MAIN = 0;
    localparam int CFG_IRQ_AUX  = 1;
    localparam int CFG_DIS_MAIN = 4;
    localparam int CFG_DIS_AUX  = 5;

    localparam int ST_OUT_FULL = 0;
    localparam int ST_IN_BUSY  = 1;
    localparam int ST_OUT_AUX  = 5;

    typedef struct packed {
        logic [7:0] cfg;
        pend_e      pend;
        logic       out_full;
        logic       out_aux;
        logic [7:0] out_data;
    } core_t;
endpackage

// File: rtl/ps2rf_busy_timer.sv
module ps2rf_busy_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CYCLES[CW-1:0];

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/ps2rf_tx_slot.sv
module ps2rf_tx_slot #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] ld_data,
    output logic          valid,
    output logic [DW-1:0] data,
    input  logic          ready
);
    logic          vld_d, vld_q;
    logic [DW-1:0] dat_d, dat_q;

    always_comb begin
        vld_d = vld_q;
        dat_d = dat_q;
        if (load) begin
            vld_d = 1'b1;
            dat_d = ld_data;
        end else if (vld_q && ready) begin
            vld_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            dat_q <= '0;
        end else begin
            vld_q <= vld_d;
            dat_q <= dat_d;
        end
    end

    assign valid = vld_q;
    assign data  = dat_q;
endmodule

// File: rtl/ps2_regfront.sv
module ps2_regfront
    import ps2rf_pkg::*;
#(
    parameter int         ADDR_W      = 3,
    parameter int         DATA_OFS    = 0,
    parameter int         CTRL_OFS    = 4,
    parameter int         BUSY_CYCLES = 4,
    parameter logic [7:0] CFG_RESET   = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              kb_rx_valid,
    input  logic [7:0]        kb_rx_data,
    output logic              kb_rx_ready,
    input  logic              aux_rx_valid,
    input  logic [7:0]        aux_rx_data,
    output logic              aux_rx_ready,
    output logic              kb_tx_valid,
    output logic [7:0]        kb_tx_data,
    input  logic              kb_tx_ready,
    output logic              aux_tx_valid,
    output logic [7:0]        aux_tx_data,
    input  logic              aux_tx_ready,
    output logic              irq_kb,
    output logic              irq_aux
);
    localparam int NPORTS = 2;
    localparam logic [ADDR_W-1:0] DATA_A = DATA_OFS[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] CTRL_A = CTRL_OFS[ADDR_W-1:0];

    core_t st_d, st_q;

    logic sel_data, sel_ctrl;
    logic wr_data, wr_cmd, rd_data, cfg_rd, wr_any;
    logic in_busy;
    logic kb_ok, aux_ok;
    logic [7:0] status;
    logic [NPORTS-1:0] tx_load, tx_rdy, tx_vld;
    logic [7:0]        tx_dat [NPORTS];

    // address decode and handshakes
    always_comb begin
        sel_data = (bus_addr == DATA_A);
        sel_ctrl = (bus_addr == CTRL_A);
        wr_data  = bus_wr && sel_data;
        wr_cmd   = bus_wr && sel_ctrl;
        rd_data  = bus_rd && sel_data;
        wr_any   = wr_data || wr_cmd;
        cfg_rd   = wr_cmd && (bus_wdata == OP_RD_CFG);
        kb_ok    = !st_q.out_full && !st_q.cfg[CFG_DIS_MAIN] && !cfg_rd;
        aux_ok   = !st_q.out_full && !st_q.cfg[CFG_DIS_AUX] && !cfg_rd
                   && !(kb_rx_valid && kb_ok);
    end

    assign kb_rx_ready  = kb_ok;
    assign aux_rx_ready = aux_ok;

    // next-state computation
    always_comb begin
        st_d    = st_q;
        tx_load = '0;
        if (rd_data) begin
            st_d.out_full = 1'b0;
        end
        if (wr_cmd) begin
            case (bus_wdata)
                OP_WR_CFG: st_d.pend = PEND_CFG;
                OP_TO_AUX: st_d.pend = PEND_AUX;
                OP_RD_CFG: begin
                    st_d.pend     = PEND_NONE;
                    st_d.out_full = 1'b1;
                    st_d.out_aux  = 1'b0;
                    st_d.out_data = st_q.cfg;
                end
                default:   st_d.pend = PEND_NONE;
            endcase
        end
        if (wr_data) begin
            st_d.pend = PEND_NONE;
            case (st_q.pend)
                PEND_CFG: st_d.cfg = bus_wdata & CFG_MASK;
                PEND_AUX: tx_load[1] = 1'b1;
                default:  tx_load[0] = 1'b1;
            endcase
        end
        if (kb_rx_valid && kb_ok) begin
            st_d.out_full = 1'b1;
            st_d.out_aux  = 1'b0;
            st_d.out_data = kb_rx_data;
        end else if (aux_rx_valid && aux_ok) begin
            st_d.out_full = 1'b1;
            st_d.out_aux  = 1'b1;
            st_d.out_data = aux_rx_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg      <= CFG_RESET & CFG_MASK;
            st_q.pend     <= PEND_NONE;
            st_q.out_full <= 1'b0;
            st_q.out_aux  <= 1'b0;
            st_q.out_data <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    ps2rf_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_any),
        .busy  (in_busy)
    );

    assign tx_rdy = {aux_tx_ready, kb_tx_ready};

    for (genvar p = 0; p < NPORTS; p++) begin : g_tx
        ps2rf_tx_slot #(.DW(8)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (tx_load[p]),
            .ld_data (bus_wdata),
            .valid   (tx_vld[p]),
            .data    (tx_dat[p]),
            .ready   (tx_rdy[p])
        );
    end

    assign kb_tx_valid  = tx_vld[0];
    assign kb_tx_data   = tx_dat[0];
    assign aux_tx_valid = tx_vld[1];
    assign aux_tx_data  = tx_dat[1];

    // status and read mux
    always_comb begin
        status              = '0;
        status[ST_OUT_FULL] = st_q.out_full;
        status[ST_IN_BUSY]  = in_busy;
        status[ST_OUT_AUX]  = st_q.out_aux && st_q.out_full;
        bus_rdata           = '0;
        if (bus_rd) begin
            if (sel_data)      bus_rdata = st_q.out_data;
            else if (sel_ctrl) bus_rdata = status;
        end
    end

    assign irq_kb  = st_q.out_full && !st_q.out_aux && st_q.cfg[CFG_IRQ_MAIN];
    assign irq_aux = st_q.out_full &&  st_q.out_aux && st_q.cfg[CFG_IRQ_AUX];
endmodule

// File: rtl/ps2rf_checker.sv
module ps2rf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       kb_rx_valid,
    input logic       kb_rx_ready,
    input logic       aux_rx_valid,
    input logic       aux_rx_ready,
    input logic       kb_tx_valid,
    input logic [7:0] kb_tx_data,
    input logic       kb_tx_ready,
    input logic       aux_tx_valid,
    input logic [7:0] aux_tx_data,
    input logic       aux_tx_ready,
    input logic       irq_kb,
    input logic       irq_aux,
    input logic       wr_hit,
    input logic       busy,
    input logic       full,
    input logic       from_aux,
    input logic [7:0] cfg
);
    a_r6_ready_only_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (kb_rx_ready || aux_rx_ready) |-> !full);

    a_r6_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !(kb_rx_valid && kb_rx_ready && aux_rx_valid && aux_rx_ready));

    a_r7_main_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        cfg[4] |-> !kb_rx_ready);

    a_r7_aux_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        cfg[5] |-> !aux_rx_ready);

    a_r9_irq_main: assert property (@(posedge clk) disable iff (!rst_n)
        irq_kb |-> (full && !from_aux && cfg[0]));

    a_r9_irq_aux: assert property (@(posedge clk) disable iff (!rst_n)
        irq_aux |-> (full && from_aux && cfg[1]));

    a_r5_kb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (kb_tx_valid && !kb_tx_ready && !wr_hit) |=> (kb_tx_valid && $stable(kb_tx_data)));

    a_r5_aux_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_tx_valid && !aux_tx_ready && !wr_hit) |=> (aux_tx_valid && $stable(aux_tx_data)));

    a_r10_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> busy);

    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg[7] && !cfg[3]);
endmodule

bind ps2_regfront ps2rf_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .kb_rx_valid  (kb_rx_valid),
    .kb_rx_ready  (kb_rx_ready),
    .aux_rx_valid (aux_rx_valid),
    .aux_rx_ready (aux_rx_ready),
    .kb_tx_valid  (kb_tx_valid),
    .kb_tx_data   (kb_tx_data),
    .kb_tx_ready  (kb_tx_ready),
    .aux_tx_valid (aux_tx_valid),
    .aux_tx_data  (aux_tx_data),
    .aux_tx_ready (aux_tx_ready),
    .irq_kb       (irq_kb),
    .irq_aux      (irq_aux),
    .wr_hit       (wr_any),
    .busy         (in_busy),
    .full         (st_q.out_full),
    .from_aux     (st_q.out_aux),
    .cfg          (st_q.cfg)
);

// File: tb/ps2_regfront_tb.sv
module ps2_regfront_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       kb_rx_valid = 1'b0, aux_rx_valid = 1'b0;
    logic [7:0] kb_rx_data = '0, aux_rx_data = '0;
    logic       kb_rx_ready, aux_rx_ready;
    logic       kb_tx_valid, aux_tx_valid;
    logic [7:0] kb_tx_data, aux_tx_data;
    logic       kb_tx_ready = 1'b0, aux_tx_ready = 1'b0;
    logic       irq_kb, irq_aux;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    ps2_regfront #(.BUSY_CYCLES(BUSY)) u_dut (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%02h exp=%02h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [2:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [7:0] v);
        do_wr(3'd4, 8'h60);
        do_wr(3'd0, v);
        idle(BUSY);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=00 exp=01");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state (R2, R3)
        do_rd(3'd4, r); chk("R2 reset status", r, 8'h00);
        chk("R9 reset irq", {6'd0, irq_aux, irq_kb}, 8'h00);
        chk("R5 reset tx", {6'd0, aux_tx_valid, kb_tx_valid}, 8'h00);
        do_wr(3'd4, 8'h20); idle(BUSY);
        do_rd(3'd4, r); chk("R3 cfg-read status", r, 8'h01);
        do_rd(3'd0, r); chk("R3 reset cfg", r, 8'h04);
        do_rd(3'd4, r); chk("R8 status after data read", r, 8'h00);

        // configuration sweep (R3, R11)
        for (int v = 0; v < 256; v++) begin
            do_wr(3'd4, 8'h60);
            do_wr(3'd0, v[7:0]);
            do_wr(3'd4, 8'h20);
            do_rd(3'd0, r);
            chk("R3 cfg write/read sweep", r, v[7:0] & 8'h77);
        end
        chk("R3 no tx from cfg writes", {6'd0, aux_tx_valid, kb_tx_valid}, 8'h00);
        set_cfg(8'h04);

        // transmit routing (R4, R5)
        do_wr(3'd0, 8'h5A);
        chk("R4 main tx valid", {6'd0, aux_tx_valid, kb_tx_valid}, 8'h01);
        chk("R4 main tx data", kb_tx_data, 8'h5A);
        idle(2);
        chk("R5 main tx held", {7'd0, kb_tx_valid}, 8'h01);
        chk("R5 main tx data stable", kb_tx_data, 8'h5A);
        kb_tx_ready = 1'b1; @(negedge clk); kb_tx_ready = 1'b0;
        chk("R5 main tx drained", {7'd0, kb_tx_valid}, 8'h00);

        do_wr(3'd4, 8'hD4);
        do_wr(3'd0, 8'h33);
        chk("R4 aux tx valid", {6'd0, aux_tx_valid, kb_tx_valid}, 8'h02);
        chk("R4 aux tx data", aux_tx_data, 8'h33);
        aux_tx_ready = 1'b1; @(negedge clk); aux_tx_ready = 1'b0;
        chk("R5 aux tx drained", {7'd0, aux_tx_valid}, 8'h00);
        do_wr(3'd0, 8'h44);
        chk("R4 pending consumed", {6'd0, aux_tx_valid, kb_tx_valid}, 8'h01);
        chk("R4 main data after aux", kb_tx_data, 8'h44);
        kb_tx_ready = 1'b1; @(negedge clk); kb_tx_ready = 1'b0;

        do_wr(3'd4, 8'hD4);
        do_wr(3'd4, 8'hAA);
        do_wr(3'd0, 8'h11);
        chk("R4 other command cancels", {6'd0, aux_tx_valid, kb_tx_valid}, 8'h01);
        kb_tx_ready = 1'b1; @(negedge clk); kb_tx_ready = 1'b0;

        // busy window (R10)
        do_wr(3'd0, 8'h22);
        for (int k = 0; k <= BUSY; k++) begin
            do_rd(3'd4, r);
            chk("R10 busy window", {7'd0, r[1]}, (k < BUSY) ? 8'h01 : 8'h00);
        end
        kb_tx_ready = 1'b1; @(negedge clk); kb_tx_ready = 1'b0;

        // receive sweep over enable/disable patterns (R6, R7, R8, R9)
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 2; p++) begin
                logic [7:0] cv, b;
                bit acc;
                cv = {2'b00, c[3], c[2], 2'b01, c[1], c[0]};
                b  = 8'h80 + 8'(c * 2 + p);
                set_cfg(cv);
                acc = (p == 0) ? !cv[4] : !cv[5];
                if (p == 0) begin
                    kb_rx_valid = 1'b1; kb_rx_data = b; #1;
                    chk("R7 main ready vs disable", {7'd0, kb_rx_ready}, {7'd0, acc});
                end else begin
                    aux_rx_valid = 1'b1; aux_rx_data = b; #1;
                    chk("R7 aux ready vs disable", {7'd0, aux_rx_ready}, {7'd0, acc});
                end
                @(negedge clk);
                kb_rx_valid = 1'b0; aux_rx_valid = 1'b0;
                do_rd(3'd4, r);
                chk("R6 status tag", r, acc ? ((p == 1) ? 8'h21 : 8'h01) : 8'h00);
                chk("R9 irq pattern", {6'd0, irq_aux, irq_kb},
                    {6'd0, acc && p == 1 && cv[1], acc && p == 0 && cv[0]});
                if (acc) begin
                    do_rd(3'd0, r); chk("R8 data byte", r, b);
                    do_rd(3'd4, r); chk("R8 full cleared", r, 8'h00);
                end
            end
        end

        // priority (R6)
        set_cfg(8'h07);
        kb_rx_valid = 1'b1; kb_rx_data = 8'hA1;
        aux_rx_valid = 1'b1; aux_rx_data = 8'hB2;
        @(negedge clk);
        kb_rx_valid = 1'b0;
        chk("R6 aux blocked while full", {7'd0, aux_rx_ready}, 8'h00);
        do_rd(3'd4, r); chk("R6 main wins", r, 8'h01);
        do_rd(3'd0, r); chk("R6 main byte first", r, 8'hA1);
        @(negedge clk);
        aux_rx_valid = 1'b0;
        do_rd(3'd4, r); chk("R6 aux next", r, 8'h21);
        chk("R9 aux irq", {6'd0, irq_aux, irq_kb}, 8'h02);
        do_rd(3'd0, r); chk("R6 aux byte", r, 8'hB2);

        // unmapped offsets (R1)
        do_wr(3'd2, 8'h99);
        chk("R1 unmapped write no tx", {6'd0, aux_tx_valid, kb_tx_valid}, 8'h00);
        do_rd(3'd4, r); chk("R1 unmapped write no busy", r, 8'h00);
        do_wr(3'd4, 8'h20); idle(BUSY);
        do_rd(3'd2, r); chk("R1 unmapped read zero", r, 8'h00);
        do_rd(3'd0, r); chk("R1 data offset read", r, 8'h07);

        // translation bit no effect (R11)
        set_cfg(8'h44);
        kb_rx_valid = 1'b1; kb_rx_data = 8'h1C;
        @(negedge clk);
        kb_rx_valid = 1'b0;
        do_rd(3'd0, r); chk("R11 byte unchanged", r, 8'h1C);
        do_wr(3'd4, 8'h20); idle(BUSY);
        do_rd(3'd0, r); chk("R11 bit stored", r, 8'h44);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule